// File: doc/BRIEF.md
# Tri-Level SAR Conversion Sequencer

This block runs the digital side of one conversion in a differential successive-approximation converter. Its resolution is 12 bits and it carries three extra redundant decisions, so one conversion takes 15 comparator decisions. After an accepted start it spends one cycle tracking the input. The step cycles then follow, one per decision. A one-hot ring of registers moves through these phases.

At the end of every step cycle the comparator result is stored in a 15-bit raw-code register, filling it from the top bit down. The same result is sent at once to the switch pair of the next, lower capacitor. One side of that pair moves from common-mode to the reference and the other side moves to ground. The first capacitor never moves. The last decision moves nothing. The decision weights are 2048, 1024, 512, 256, 256, 128, 64, 32, 32, 16, 8, 4, 4, 2, 1. A downstream stage folds them into the 12-bit result. When the last decision has been stored, the sequencer raises done for one cycle and returns every switch to common-mode.

Top module: `tl_sar_sequencer`

## Requirements
- R1: After reset, sample_en and done are 0, raw_code is 0 and every switch field reads 00 (common-mode).
- R2: A start seen at a clock edge while the sequencer is idle, or while it is in its done cycle, makes sample_en high for exactly the next cycle.
- R3: The 15 cycles after the sample cycle are decision steps k = 0..14. The value of cmp_in at the clock edge that ends step k is stored in raw_code bit 14-k. Lower bits stay 0 until they are decided.
- R4: The capacitor weighted by the first decision has no switch. Field j (bits 2j+1:2j of sw_p and sw_n) drives the capacitor of step j+1. All fields read 00 during the sample cycle and during step 0.
- R5: Field j changes only at the edge that ends step j. A stored 1 drives sw_p=10 (ground) and sw_n=01 (reference). A stored 0 drives sw_p=01 and sw_n=10. Fields of steps not yet decided stay 00.
- R6: The decision of step 14 switches no capacitor. In the cycle after step 14, done is 1 for exactly one cycle, every field reads 00 and raw_code holds all 15 decisions.
- R7: A start that arrives during the sample cycle or any step cycle is ignored. The raw code, the switch sequence and the timing of done are unchanged.
- R8: The code 11 never appears in any switch field.
- R9: raw_code keeps its value after done until the next accepted start. It reads 0 in that start's sample cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a conversion |
| cmp_in | input | 1 | Comparator decision, 1 when the positive side is higher |
| sample_en | output | 1 | High during the input tracking cycle |
| sw_p | output | 28 | Positive-side switch commands, 2 bits per switched capacitor |
| sw_n | output | 28 | Negative-side switch commands, 2 bits per switched capacitor |
| raw_code | output | 15 | Stored decisions, first decision in bit 14 |
| done | output | 1 | One-cycle pulse after the final decision |

## Verification
The hardest case to reach is a start that arrives mid-conversion and might restart the ring or clear the code register half-filled. The stimulus holds start high from the sample cycle through the final step for some conversions. It then checks every step's code and switch image against the values expected with no restart. A start is also placed in the done cycle itself, to show that it is accepted there and clears the code one cycle later. The decision patterns sweep all-zero, all-one, alternating, every walking one and a run of pseudo-random words. These bring every switch field to both of its driven values, step by step.

// File: rtl/tls_pkg.sv
package tls_pkg;

   typedef enum logic [1:0] {
      SW_CM  = 2'b00,
      SW_REF = 2'b01,
      SW_GND = 2'b10
   } sw_cmd_e;

   // positive side moves to ground when the comparator says the positive side is higher
   function automatic sw_cmd_e pos_side_cmd(input logic decision);
      return decision ? SW_GND : SW_REF;
   endfunction

   function automatic sw_cmd_e neg_side_cmd(input logic decision);
      return decision ? SW_REF : SW_GND;
   endfunction

   // weight of decision step k for a binary search with repeated redundant weights
   function automatic int unsigned step_weight(input int unsigned k,
                                               input int unsigned res_bits,
                                               input int unsigned n_red,
                                               input int unsigned red_gap);
      int unsigned bit_pos;
      int unsigned idx;
      bit_pos = res_bits - 1;
      idx = 0;
      for (int unsigned b = res_bits; b > 0; b--) begin
         if (idx == k) return (1 << (b - 1));
         idx++;
         for (int unsigned r = 0; r < n_red; r++) begin
            if ((b - 1) == (res_bits - 1 - red_gap * (r + 1))) begin
               if (idx == k) return (1 << (b - 1));
               idx++;
            end
         end
      end
      return bit_pos - bit_pos;
   endfunction

endpackage

// File: rtl/tls_ring.sv
module tls_ring #(
   parameter int N_STEPS = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic               accept,
   output logic               busy,
   output logic               sample,
   output logic [N_STEPS-1:0] step_oh,
   output logic               done
);
   localparam int RING_W = N_STEPS + 2;

   logic [RING_W-1:0] ring_q;

   assign busy   = |ring_q[RING_W-2:0];
   assign accept = start & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_q <= '0;
      end else begin
         ring_q <= {ring_q[RING_W-2:0], accept};
      end
   end

   assign sample  = ring_q[0];
   assign step_oh = ring_q[N_STEPS:1];
   assign done    = ring_q[RING_W-1];

endmodule

// File: rtl/tls_code_reg.sv
module tls_code_reg #(
   parameter int N_STEPS = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic [N_STEPS-1:0] step_oh,
   input  logic               cmp,
   output logic [N_STEPS-1:0] code
);
   genvar gi;
   generate
      for (gi = 0; gi < N_STEPS; gi++) begin : g_bit
         localparam int STEP = N_STEPS - 1 - gi;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               code[gi] <= 1'b0;
            end else if (clear) begin
               code[gi] <= 1'b0;
            end else if (step_oh[STEP]) begin
               code[gi] <= cmp;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tls_switch_bank.sv
module tls_switch_bank
   import tls_pkg::*;
#(
   parameter int N_STEPS = 15
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic [N_STEPS-1:0]     step_oh,
   input  logic                   cmp,
   output logic [2*N_STEPS-3:0]   sw_p,
   output logic [2*N_STEPS-3:0]   sw_n
);
   localparam int N_CAP = N_STEPS - 1;

   logic release_all;
   assign release_all = clear | step_oh[N_STEPS-1];

   genvar gj;
   generate
      for (gj = 0; gj < N_CAP; gj++) begin : g_cap
         sw_cmd_e p_q, n_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               p_q <= SW_CM;
               n_q <= SW_CM;
            end else if (release_all) begin
               p_q <= SW_CM;
               n_q <= SW_CM;
            end else if (step_oh[gj]) begin
               p_q <= pos_side_cmd(cmp);
               n_q <= neg_side_cmd(cmp);
            end
         end
         assign sw_p[2*gj+1:2*gj] = p_q;
         assign sw_n[2*gj+1:2*gj] = n_q;
      end
   endgenerate

endmodule

// File: rtl/tl_sar_sequencer.sv
module tl_sar_sequencer #(
   parameter int RES_BITS = 12,
   parameter int N_RED    = 3,
   parameter int RED_GAP  = 3,
   parameter int N_STEPS  = RES_BITS + N_RED,
   parameter int N_CAP    = N_STEPS - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 cmp_in,
   output logic                 sample_en,
   output logic [2*N_CAP-1:0]   sw_p,
   output logic [2*N_CAP-1:0]   sw_n,
   output logic [N_STEPS-1:0]   raw_code,
   output logic                 done
);
   generate
      if (RES_BITS < 2) begin : g_bad_res
         $error("RES_BITS must be at least 2");
      end
      if (N_STEPS != RES_BITS + N_RED) begin : g_bad_steps
         $error("N_STEPS must equal RES_BITS + N_RED");
      end
      if (N_CAP != N_STEPS - 1) begin : g_bad_cap
         $error("N_CAP must equal N_STEPS - 1");
      end
      if (N_RED > 0 && N_RED * RED_GAP >= RES_BITS) begin : g_bad_gap
         $error("redundant steps must fall inside the binary range");
      end
      if (N_STEPS > 64) begin : g_bad_len
         $error("ring length limited to 64 steps");
      end
   endgenerate

   logic               accept;
   logic               busy;
   logic [N_STEPS-1:0] step_oh;

   tls_ring #(.N_STEPS(N_STEPS)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .accept  (accept),
      .busy    (busy),
      .sample  (sample_en),
      .step_oh (step_oh),
      .done    (done)
   );

   tls_code_reg #(.N_STEPS(N_STEPS)) u_code (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .step_oh (step_oh),
      .cmp     (cmp_in),
      .code    (raw_code)
   );

   tls_switch_bank #(.N_STEPS(N_STEPS)) u_sw (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .step_oh (step_oh),
      .cmp     (cmp_in),
      .sw_p    (sw_p),
      .sw_n    (sw_n)
   );

endmodule

// File: rtl/tls_checker.sv
module tls_checker #(
   parameter int N_STEPS = 15,
   parameter int N_CAP   = N_STEPS - 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               sample_en,
   input logic [2*N_CAP-1:0] sw_p,
   input logic [2*N_CAP-1:0] sw_n,
   input logic [N_STEPS-1:0] raw_code,
   input logic               done
);
   // R2: start while idle leads to the sample cycle
   p_sample_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> sample_en);

   // R2: sample lasts one cycle
   p_sample_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |=> !sample_en);

   // R4: step 0 runs with every switch at common-mode
   p_msb_no_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |=> (sw_p == '0 && sw_n == '0));

   // R6: done is a single-cycle pulse with all switches released
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (sw_p == '0 && sw_n == '0));

   // R7: a start during a conversion does not restart sampling
   p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !sample_en) |=> !sample_en);

   // R9: code held after done unless a new start is accepted
   p_raw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable(raw_code));

   genvar gk;
   generate
      for (gk = 0; gk < N_CAP; gk++) begin : g_field
         // R8: illegal code never driven
         p_no_illegal_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_p[2*gk+1:2*gk] != 2'b11) && (sw_n[2*gk+1:2*gk] != 2'b11));
         // R5: both sides leave common-mode together and in opposite directions
         p_sides_paired_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_p[2*gk+1:2*gk] == 2'b00) == (sw_n[2*gk+1:2*gk] == 2'b00));
      end
   endgenerate

endmodule

bind tl_sar_sequencer tls_checker #(.N_STEPS(N_STEPS), .N_CAP(N_CAP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .sample_en (sample_en),
   .sw_p      (sw_p),
   .sw_n      (sw_n),
   .raw_code  (raw_code),
   .done      (done)
);

// File: tb/tl_sar_sequencer_tb.sv
module tl_sar_sequencer_tb;
   localparam int NS = 15;
   localparam int NC = NS - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          cmp_in = 1'b0;
   logic          sample_en;
   logic [2*NC-1:0] sw_p, sw_n;
   logic [NS-1:0] raw_code;
   logic          done;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   tl_sar_sequencer u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
      .sample_en(sample_en), .sw_p(sw_p), .sw_n(sw_n),
      .raw_code(raw_code), .done(done)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // expected switch image after k decisions: field j set by decision j for j < k
   function automatic logic [2*NC-1:0] exp_sw(input logic [NS-1:0] pat, input int k, input bit pside);
      logic [2*NC-1:0] v = '0;
      for (int j = 0; j < NC; j++) begin
         if (j < k) begin
            if (pat[NS-1-j]) v[2*j +: 2] = pside ? 2'b10 : 2'b01;
            else             v[2*j +: 2] = pside ? 2'b01 : 2'b10;
         end
      end
      return v;
   endfunction

   function automatic logic [NS-1:0] exp_raw(input logic [NS-1:0] pat, input int k);
      logic [NS-1:0] m = '0;
      for (int b = 0; b < NS; b++) if (b >= NS - k) m[b] = 1'b1;
      return pat & m;
   endfunction

   function automatic bit has_11(input logic [2*NC-1:0] v);
      for (int j = 0; j < NC; j++) if (v[2*j +: 2] == 2'b11) return 1'b1;
      return 1'b0;
   endfunction

   // one conversion; caller is at a negedge with idle or done state
   task automatic convert(input logic [NS-1:0] pat, input bit hold_start);
      start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = hold_start;
      chk("R2", "sample_en in sample cycle", sample_en, 1);
      chk("R9", "raw cleared in sample cycle", raw_code, 0);
      chk("R4", "sw_p in sample cycle", sw_p, 0);
      for (int k = 0; k < NS; k++) begin
         @(posedge clk); @(negedge clk);
         cmp_in = pat[NS-1-k];
         chk("R2", "sample_en low during steps", sample_en, 0);
         chk("R3", "raw during step", raw_code, exp_raw(pat, k));
         chk(k == 0 ? "R4" : "R5", "sw_p during step", sw_p, exp_sw(pat, k, 1'b1));
         chk(k == 0 ? "R4" : "R5", "sw_n during step", sw_n, exp_sw(pat, k, 1'b0));
         chk("R8", "no 11 field", has_11(sw_p) | has_11(sw_n), 0);
         if (hold_start) chk("R7", "done low while busy", done, 0);
      end
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      chk("R6", "done pulse", done, 1);
      chk("R6", "raw complete", raw_code, pat);
      chk("R6", "switches released", {sw_p, sw_n}, 0);
      @(posedge clk); @(negedge clk);
      chk("R6", "done single cycle", done, 0);
      chk("R9", "raw held after done", raw_code, pat);
      chk("R7", "no extra sample", sample_en, 0);
   endtask

   initial begin
      logic [NS-1:0] lfsr;
      #1;
      chk("R1", "reset outputs", {sample_en, done}, 0);
      chk("R1", "reset raw", raw_code, 0);
      chk("R1", "reset switches", {sw_p, sw_n}, 0);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "idle after reset", {sample_en, done, raw_code}, 0);

      convert(15'h0000, 1'b0);
      convert(15'h7FFF, 1'b1);
      convert(15'h5555, 1'b0);
      convert(15'h2AAA, 1'b1);
      for (int w = 0; w < NS; w++) convert(15'(1 << w), w[0]);
      lfsr = 15'h1ACE;
      for (int r = 0; r < 20; r++) begin
         lfsr = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
         convert(lfsr, r[1]);
      end

      // R9: code holds through idle cycles
      repeat (3) @(negedge clk);
      chk("R9", "raw held while idle", raw_code, lfsr);

      // R2/R9: start in the done cycle is accepted
      start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < NS; k++) begin
         @(posedge clk); @(negedge clk);
         cmp_in = 1'b1;
      end
      @(posedge clk); @(negedge clk);
      chk("R6", "done before back-to-back", done, 1);
      start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      chk("R2", "start in done cycle accepted", sample_en, 1);
      chk("R9", "raw cleared on new start", raw_code, 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule